// File: doc/BRIEF.md
# Two-Level Interrupt Gate Controller

This controller collects level-sensitive interrupt lines and presents one interrupt request per CPU in a small multiprocessor of up to four CPUs. A line reaches a CPU only after it passes two gates. The first is an enable that all CPUs share. The second is a mask that belongs to that one CPU. Lines numbered 29 and up are shared device interrupts. For these, a routing word also picks which CPUs may receive them.

Software drives the block through a simple register port. That port has a shared region and a per-CPU region. In the per-CPU region, the `bus_cpu` input names the CPU making the access. Enables and masks are never edited as bitmaps. Software writes an interrupt number to a set register or a clear register instead. An acknowledge register returns the lowest-numbered line pending for the CPU that reads it.

Lines 0 and 1 are internal summary lines. For each CPU, they come from the inter-CPU doorbell summary and the message doorbell summary.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, these hold:
  - all global enables are clear, every per-CPU mask is set and all routing words are zero;
  - no `irq_out` bit is high;
  - the acknowledge read returns 1023;
  - shared offset 0x000 reads NUM_SRC in bits [11:2].
- R2: Writing an interrupt number to shared offset 0x030 sets its global enable. Writing it to shared offset 0x034 clears that enable.
- R3: In the per-CPU region, writing a number to offset 0x048 masks that line for CPU `bus_cpu` only. Writing it to offset 0x04C unmasks it for that CPU only.
- R4: A line numbered 28 or below is pending for CPU k when all of these hold: it is asserted, it is globally enabled, and it is unmasked for k. Its routing word is not consulted.
- R5: A line n above 28 also needs bit k or bit 8+k of its routing word set. The routing word sits at shared offset 0x100+4n and reads back with the same bits.
- R6: Reading per-CPU offset 0x044 returns, in bits [9:0], the lowest line pending for that CPU. It returns 1023 when no line is pending.
- R7: For CPU k, line 0 is `ipi_sum[k]` and line 1 is `msi_sum[k]`. Bits 0 and 1 of `src_in` have no effect.
- R8: A set or clear write whose number is NUM_SRC or larger changes no enable and no mask. This holds even when the number's low bits name a real line.
- R9: `irq_out[k]` is high when any line is pending for CPU k. It follows a register write or an input change after one clock edge. Read data appears one edge after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_region | input | 1 | 0 selects the shared region, 1 selects the per-CPU region |
| bus_cpu | input | CPU_W | CPU making the access |
| bus_addr | input | ADDR_W | Byte offset within the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | NUM_SRC | Level-sensitive device lines; bits 0 and 1 are ignored |
| ipi_sum | input | NUM_CPU | Per-CPU inter-CPU doorbell summary (line 0) |
| msi_sum | input | NUM_CPU | Per-CPU message doorbell summary (line 1) |
| irq_out | output | NUM_CPU | Interrupt request per CPU, registered |

## Verification
Each result has a fixed due cycle:
- A write lands on the edge that samples it.
- The acknowledge value is combinational from the stored state, so a read one cycle after a write already sees the write.
- `irq_out` changes one edge after the write or the input change that caused it.
- Read data is captured on the edge that samples `bus_rd`.

The driver changes inputs on falling edges and queues the expected read value. The monitor compares the read value at the next falling edge, after the capturing rising edge. The interrupt checks sample one falling edge after the stimulus. For R9, one check is made before the edge and one after it, so a missing or an extra register stage shows up.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;
   localparam int OFS_CTRL     = 'h000;
   localparam int OFS_EN_SET   = 'h030;
   localparam int OFS_EN_CLR   = 'h034;
   localparam int OFS_ACK      = 'h044;
   localparam int OFS_MSK_SET  = 'h048;
   localparam int OFS_MSK_CLR  = 'h04C;
   localparam int OFS_ROUTE    = 'h100;
   localparam int FIQ_ROUTE_LSB = 8;
   localparam int ACK_W        = 10;
   localparam int ACK_NONE     = 1023;
   localparam int PERCPU_LAST  = 28;

   typedef enum logic {
      RGN_SHARED = 1'b0,
      RGN_CPU    = 1'b1
   } region_e;
endpackage

// File: rtl/irqg_regs.sv
`timescale 1ns/1ps
module irqg_regs
   import irqg_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 2,
   parameter int CPU_W   = 1,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic                              region,
   input  logic [CPU_W-1:0]                  cpu,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [NUM_SRC-1:0]                gen_en,
   output logic [NUM_CPU-1:0][NUM_SRC-1:0]   cpu_mask,
   output logic [NUM_SRC-1:0][NUM_CPU-1:0]   rt_irq,
   output logic [NUM_SRC-1:0][NUM_CPU-1:0]   rt_fiq,
   output logic                              rt_hit,
   output logic [DATA_W-1:0]                 rt_word
);
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int RT_TOP  = OFS_ROUTE + 4 * NUM_SRC;

   logic             num_ok, cpu_ok, is_shared, is_cpu;
   logic [IDX_W-1:0] idx, rt_idx;
   logic [ADDR_W-1:0] rt_off;
   logic             w_en_set, w_en_clr, w_msk_set, w_msk_clr, w_rt;

   always_comb begin
      num_ok    = (wdata < DATA_W'(NUM_SRC));
      idx       = wdata[IDX_W-1:0];
      cpu_ok    = (32'(cpu) < 32'(NUM_CPU));
      is_shared = (region == RGN_SHARED);
      is_cpu    = (region == RGN_CPU);
      rt_off    = addr - ADDR_W'(OFS_ROUTE);
      rt_idx    = rt_off[IDX_W+1:2];
      rt_hit    = is_shared && (32'(addr) >= OFS_ROUTE) && (32'(addr) < RT_TOP)
                  && (addr[1:0] == 2'b00);
      w_en_set  = wr && is_shared && (32'(addr) == OFS_EN_SET) && num_ok;
      w_en_clr  = wr && is_shared && (32'(addr) == OFS_EN_CLR) && num_ok;
      w_msk_set = wr && is_cpu && cpu_ok && (32'(addr) == OFS_MSK_SET) && num_ok;
      w_msk_clr = wr && is_cpu && cpu_ok && (32'(addr) == OFS_MSK_CLR) && num_ok;
      w_rt      = wr && rt_hit;
      rt_word   = '0;
      rt_word[NUM_CPU-1:0] = rt_irq[rt_idx];
      rt_word[FIQ_ROUTE_LSB +: NUM_CPU] = rt_fiq[rt_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_en   <= '0;
         cpu_mask <= '1;
         rt_irq   <= '0;
         rt_fiq   <= '0;
      end else begin
         if (w_en_set)  gen_en[idx] <= 1'b1;
         if (w_en_clr)  gen_en[idx] <= 1'b0;
         if (w_msk_set) cpu_mask[cpu][idx] <= 1'b1;
         if (w_msk_clr) cpu_mask[cpu][idx] <= 1'b0;
         if (w_rt) begin
            rt_irq[rt_idx] <= wdata[NUM_CPU-1:0];
            rt_fiq[rt_idx] <= wdata[FIQ_ROUTE_LSB +: NUM_CPU];
         end
      end
   end

   // Assertions next to the gate storage
   assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      w_en_set |=> gen_en[$past(idx)]);
   assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      w_en_clr |=> !gen_en[$past(idx)]);
   assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_msk_clr |=> !cpu_mask[$past(cpu)][$past(idx)]);
   assert_oor_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !num_ok && !rt_hit) |=> ($stable(gen_en) && $stable(cpu_mask)));
endmodule

// File: rtl/irqg_pend.sv
`timescale 1ns/1ps
module irqg_pend
   import irqg_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lvl,
   input  logic [NUM_SRC-1:0] gen_en,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_SRC-1:0] routed,
   output logic [ACK_W-1:0]   ack_num,
   output logic               irq_q
);
   logic [NUM_SRC-1:0] pend;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      if (i <= PERCPU_LAST) begin : g_local
         assign pend[i] = lvl[i] && gen_en[i] && !mask[i];
      end else begin : g_shared
         assign pend[i] = lvl[i] && gen_en[i] && !mask[i] && routed[i];
      end
   end

   always_comb begin
      ack_num = ACK_W'(ACK_NONE);
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) ack_num = ACK_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end

   assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|pend));
   assert_ack_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(ack_num) < NUM_SRC) |-> pend[ack_num]);
   assert_ack_routed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(ack_num) > PERCPU_LAST) && (32'(ack_num) < NUM_SRC)) |-> routed[ack_num]);
endmodule

// File: rtl/irq_gate_ctrl.sv
`timescale 1ns/1ps
module irq_gate_ctrl
   import irqg_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 2,
   parameter int ADDR_W  = 12,
   parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic               bus_region,
   input  logic [CPU_W-1:0]   bus_cpu,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [NUM_CPU-1:0] ipi_sum,
   input  logic [NUM_CPU-1:0] msi_sum,
   output logic [NUM_CPU-1:0] irq_out
);
   localparam int DATA_W = 32;

   if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("NUM_CPU must be 1..4");
   end
   if (NUM_SRC < 3 || NUM_SRC > 1020) begin : g_bad_src
      $error("NUM_SRC must be 3..1020");
   end
   if (OFS_ROUTE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for routing words");
   end

   logic [NUM_SRC-1:0]              gen_en;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_mask;
   logic [NUM_SRC-1:0][NUM_CPU-1:0] rt_irq, rt_fiq;
   logic                            rt_hit;
   logic [DATA_W-1:0]               rt_word, rd_mux;
   logic [NUM_CPU-1:0][ACK_W-1:0]   ack_all;

   irqg_regs #(
      .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .region(bus_region),
      .cpu(bus_cpu), .addr(bus_addr), .wdata(bus_wdata),
      .gen_en(gen_en), .cpu_mask(cpu_mask), .rt_irq(rt_irq), .rt_fiq(rt_fiq),
      .rt_hit(rt_hit), .rt_word(rt_word)
   );

   for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
      logic [NUM_SRC-1:0] lvl_k, routed_k;
      always_comb begin
         lvl_k    = src_in;
         lvl_k[0] = ipi_sum[k];
         lvl_k[1] = msi_sum[k];
         for (int i = 0; i < NUM_SRC; i++) routed_k[i] = rt_irq[i][k] || rt_fiq[i][k];
      end
      irqg_pend #(.NUM_SRC(NUM_SRC)) i_pend (
         .clk(clk), .rst_n(rst_n), .lvl(lvl_k), .gen_en(gen_en),
         .mask(cpu_mask[k]), .routed(routed_k),
         .ack_num(ack_all[k]), .irq_q(irq_out[k])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (bus_region == RGN_SHARED) begin
         if (32'(bus_addr) == OFS_CTRL) rd_mux[11:2] = 10'(NUM_SRC);
         else if (rt_hit)               rd_mux = rt_word;
      end else if (32'(bus_addr) == OFS_ACK) begin
         if (32'(bus_cpu) < NUM_CPU) rd_mux[ACK_W-1:0] = ack_all[bus_cpu];
         else                        rd_mux[ACK_W-1:0] = ACK_W'(ACK_NONE);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/test_irq_gate_ctrl.sv
`timescale 1ns/1ps
module test_irq_gate_ctrl;
   localparam int NS = 64;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_region = 1'b0;
   logic [0:0]    bus_cpu = '0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] src_in = '0;
   logic [NC-1:0] ipi_sum = '0, msi_sum = '0;
   logic [NC-1:0] irq_out;

   int tests = 0, fails = 0;
   bit done = 0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t sbq[$];
   logic rd_d = 1'b0;

   always #2.5 clk = ~clk;

   irq_gate_ctrl i_irq_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_region(bus_region), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .ipi_sum(ipi_sum), .msi_sum(msi_sum), .irq_out(irq_out)
   );

   // monitor: read data is due on the edge that samples bus_rd
   always @(posedge clk) rd_d <= bus_rd;
   always @(negedge clk) begin
      if (rd_d && sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         tests++;
         if (bus_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: rdata=%0d expected %0d", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic rg, input int cpu, input int a, input int d);
      @(negedge clk);
      bus_wr = 1; bus_region = rg; bus_cpu = 1'(cpu);
      bus_addr = 12'(a); bus_wdata = 32'(d);
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic rg, input int cpu, input int a, input int exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_rd = 1; bus_region = rg; bus_cpu = 1'(cpu); bus_addr = 12'(a);
      it.exp = 32'(exp); it.tag = tag;
      sbq.push_back(it);
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic chk_irq(input logic [NC-1:0] exp, input string tag);
      tests++;
      if (irq_out !== exp) begin
         fails++;
         $display("FAIL %s: irq_out=%b expected %b", tag, irq_out, exp);
      end
   endtask

   task automatic step_irq(input logic [NC-1:0] exp, input string tag);
      @(negedge clk);
      chk_irq(exp, tag);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      step_irq(2'b00, "R1 irq after reset");
      rd(0, 0, 'h000, NS << 2, "R1 control readback");
      rd(1, 0, 'h044, 1023, "R1 ack cpu0 empty");
      rd(1, 1, 'h044, 1023, "R1 ack cpu1 empty");
      // R3/R4 local source 5
      src_in[5] = 1;
      wr(0, 0, 'h030, 5);
      step_irq(2'b00, "R3 enabled but masked");
      wr(1, 0, 'h04C, 5);
      step_irq(2'b01, "R4 local line needs no route");
      rd(1, 0, 'h044, 5, "R6 ack cpu0 line 5");
      rd(1, 1, 'h044, 1023, "R3 cpu1 still masked");
      // R2 clear/set enable
      wr(0, 0, 'h034, 5);
      step_irq(2'b00, "R2 enable cleared");
      wr(0, 0, 'h030, 5);
      step_irq(2'b01, "R2 enable set again");
      // R5 shared line 40
      src_in[40] = 1;
      wr(0, 0, 'h030, 40);
      wr(1, 1, 'h04C, 40);
      step_irq(2'b01, "R5 unrouted shared line");
      wr(0, 0, 'h100 + 4*40, 'h200);
      step_irq(2'b11, "R5 route via bit 9");
      rd(0, 0, 'h100 + 4*40, 'h200, "R5 route word readback");
      rd(1, 1, 'h044, 40, "R5 ack cpu1 line 40");
      // R6 lowest first
      wr(1, 1, 'h04C, 5);
      rd(1, 1, 'h044, 5, "R6 lowest number wins");
      wr(1, 1, 'h048, 5);
      rd(1, 1, 'h044, 40, "R3 mask set for cpu1");
      rd(1, 0, 'h044, 5, "R3 cpu0 unaffected by cpu1 mask");
      // R7 summary lines
      msi_sum[1] = 1;
      src_in[1] = 1;
      wr(0, 0, 'h030, 1);
      wr(1, 1, 'h04C, 1);
      wr(1, 0, 'h04C, 1);
      rd(1, 1, 'h044, 1, "R7 msi summary for cpu1");
      rd(1, 0, 'h044, 5, "R7 src_in bit1 ignored");
      // R8 out-of-range numbers
      msi_sum[1] = 0;
      wr(0, 0, 'h034, 64 + 5);
      rd(1, 0, 'h044, 5, "R8 oversized clear ignored");
      wr(1, 1, 'h048, 64 + 40);
      rd(1, 1, 'h044, 40, "R8 oversized mask ignored");
      // R9 one-edge latency
      @(negedge clk);
      src_in[5] = 0;
      chk_irq(2'b11, "R9 before edge");
      step_irq(2'b10, "R9 after one edge");
      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule